// File: doc/BRIEF.md
# Bitfield Extract and Insert Unit

This block is the bitfield datapath of a small macro processor. It takes an instruction word and two 32-bit register operands, A and B, and returns a 32-bit result in the same cycle. It does not decide the order of instructions or write anything back.

It supports three operations. All of them read one field of B, but they take their shift amounts from different places:
- **Insert** places that field of B into A and leaves the other bits of A unchanged.
- **Dynamic-source extract** moves the field to a fixed position, but takes the read offset from register A.
- **Dynamic-destination extract** reads the field at a fixed offset, but takes the placement shift from register A.

All three operations use the same layout for the field parameters in the instruction word. A shift amount that comes from a register can hold any 32-bit value. Any amount of 32 or more shifts every bit out.

Top module: `bf_extract_insert`

## Requirements
- R1: The instruction word is decoded as follows. Bits [2:0] are the operation code, [21:17] the source offset, [26:22] the field width and [31:27] the destination offset. Bits [16:3] have no effect on the result.
- R2: Operation code 2 selects insert, 3 selects dynamic-source extract and 4 selects dynamic-destination extract. Any other code gives a result of zero.
- R3: Insert computes the field as (B >> source offset) masked to the width. It clears the bits of A under the mask shifted to the destination offset, then ORs in the field shifted to the same offset. The bits of A outside that window pass through unchanged.
- R4: Dynamic-source extract returns ((B >> A) & mask) << destination offset.
- R5: Dynamic-destination extract returns ((B >> source offset) & mask) << A.
- R6: The mask is 2^width − 1. A width of 1 gives 0x1 and a width of 31 gives 0x7FFFFFFF, with no overflow.
- R7: A width of 0 makes insert return A unchanged and makes both extracts return zero.
- R8: When a shift amount taken from register A is 32 or larger, the shifted value is zero. The amount does not wrap modulo 32.
- R9: The result depends only on the present inputs. There is no storage and no latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word holding the operation code and the field parameters |
| a_i | input | 32 | Register operand A: insert target, or the dynamic shift amount |
| b_i | input | 32 | Register operand B: the source of the field |
| result_o | output | 32 | Combinational result |

## Verification
The bench builds the unit with the package defaults: a 32-bit datapath and 5-bit offset and width fields, with the field parameters starting at bit 17. At these values the widest mask (width 31) is reachable, the register-supplied shift amounts can cross the 32 boundary, and fields shifted past bit 31 are cut off. Directed cases cover widths 0, 1 and 31, shift amounts of 32, 40 and all ones, junk in the unused instruction bits, and undefined operation codes. Several hundred random words are then compared against a 64-bit reference model.

// File: rtl/bf_pkg.sv
package bf_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned POS_W    = 5;
  localparam int unsigned OP_W     = 3;
  localparam int unsigned SRC_LSB  = 17;
  localparam int unsigned SIZE_LSB = SRC_LSB + POS_W;
  localparam int unsigned DST_LSB  = SIZE_LSB + POS_W;

  localparam logic [OP_W-1:0] OP_INS       = 3'd2;
  localparam logic [OP_W-1:0] OP_EXT_DSRC  = 3'd3;
  localparam logic [OP_W-1:0] OP_EXT_DDST  = 3'd4;

  typedef struct packed {
    logic [POS_W-1:0] dst;
    logic [POS_W-1:0] size;
    logic [POS_W-1:0] src;
    logic [OP_W-1:0]  op;
  } bf_fields_t;
endpackage

// File: rtl/bf_field_dec.sv
module bf_field_dec
  import bf_pkg::*;
(
  input  logic [DATA_W-1:0] instr_i,
  output bf_fields_t        fld_o
);
  logic unused_bits;

  assign fld_o.op   = instr_i[OP_W-1:0];
  assign fld_o.src  = instr_i[SRC_LSB  +: POS_W];
  assign fld_o.size = instr_i[SIZE_LSB +: POS_W];
  assign fld_o.dst  = instr_i[DST_LSB  +: POS_W];
  assign unused_bits = ^instr_i[SRC_LSB-1:OP_W];
endmodule

// File: rtl/bf_mask_gen.sv
module bf_mask_gen #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned POS_W  = 5
) (
  input  logic [POS_W-1:0]  size_i,
  output logic [DATA_W-1:0] mask_o
);
  // Shift ones up and invert: width 31 stays inside DATA_W.
  assign mask_o = ~({DATA_W{1'b1}} << size_i);

  always_comb begin
    // R6
    mask_pop_chk: assert ($countones(mask_o) == int'(size_i))
      else $error("mask popcount mismatch");
    // R6
    mask_contig_chk: assert (((mask_o + 1'b1) & mask_o) == '0)
      else $error("mask not contiguous");
  end
endmodule

// File: rtl/bf_shift.sv
module bf_shift #(
  parameter int unsigned DATA_W = 32,
  parameter bit          LEFT   = 1'b0
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] amt_i,
  output logic [DATA_W-1:0] data_o
);
  localparam int unsigned SH_W = $clog2(DATA_W);

  logic             ovr;
  logic [SH_W-1:0]  amt_lo;
  logic [DATA_W-1:0] sh;

  assign ovr    = (amt_i >= DATA_W);
  assign amt_lo = amt_i[SH_W-1:0];

  generate
    if (LEFT) begin : g_left
      assign sh = data_i << amt_lo;
    end else begin : g_right
      assign sh = data_i >> amt_lo;
    end
  endgenerate

  assign data_o = ovr ? '0 : sh;

  always_comb begin
    // R8
    ovr_zero_chk: assert (!(amt_i >= DATA_W) || data_o == '0)
      else $error("oversized shift not zero");
  end
endmodule

// File: rtl/bf_extract_insert.sv
module bf_extract_insert
  import bf_pkg::*;
(
  input  logic [DATA_W-1:0] instr_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] result_o
);
  localparam int unsigned PAD_W = DATA_W - POS_W;

  bf_fields_t        fld;
  logic [DATA_W-1:0] mask, win;
  logic [DATA_W-1:0] rsh_amt, rsh_out, field;
  logic [DATA_W-1:0] lsh_amt, lsh_out;

  bf_field_dec u_dec (.instr_i(instr_i), .fld_o(fld));

  bf_mask_gen #(.DATA_W(DATA_W), .POS_W(POS_W)) u_mask (
    .size_i(fld.size), .mask_o(mask)
  );

  // One right and one left shifter shared by all three operations.
  assign rsh_amt = (fld.op == OP_EXT_DSRC) ? a_i : {{PAD_W{1'b0}}, fld.src};
  assign lsh_amt = (fld.op == OP_EXT_DDST) ? a_i : {{PAD_W{1'b0}}, fld.dst};

  bf_shift #(.DATA_W(DATA_W), .LEFT(1'b0)) u_rsh (
    .data_i(b_i), .amt_i(rsh_amt), .data_o(rsh_out)
  );

  assign field = rsh_out & mask;

  bf_shift #(.DATA_W(DATA_W), .LEFT(1'b1)) u_lsh (
    .data_i(field), .amt_i(lsh_amt), .data_o(lsh_out)
  );

  assign win = mask << fld.dst;

  always_comb begin
    unique case (fld.op)
      OP_INS:                   result_o = (a_i & ~win) | lsh_out;
      OP_EXT_DSRC, OP_EXT_DDST: result_o = lsh_out;
      default:                  result_o = '0;
    endcase
  end

  always_comb begin
    // R2
    bad_op_chk: assert (fld.op == OP_INS || fld.op == OP_EXT_DSRC ||
                        fld.op == OP_EXT_DDST || result_o == '0)
      else $error("undefined op produced data");
    // R3
    ins_keep_chk: assert (fld.op != OP_INS || ((result_o ^ a_i) & ~win) == '0)
      else $error("insert disturbed bits outside field");
    // R7
    ins_size0_chk: assert (!(fld.op == OP_INS && fld.size == '0) || result_o == a_i)
      else $error("zero-width insert changed A");
    // R7
    ext_size0_chk: assert (!((fld.op == OP_EXT_DSRC || fld.op == OP_EXT_DDST) &&
                             fld.size == '0) || result_o == '0)
      else $error("zero-width extract non-zero");
  end
endmodule

// File: tb/bf_extract_insert_bench.sv
module bf_extract_insert_bench;
  logic        clk = 1'b0;
  logic [31:0] instr, a, b;
  logic [31:0] result;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2ns clk = ~clk;

  bf_extract_insert u_bf_extract_insert (
    .instr_i(instr), .a_i(a), .b_i(b), .result_o(result)
  );

  function automatic logic [31:0] mk(input logic [2:0] op, input logic [4:0] src,
                                     input logic [4:0] size, input logic [4:0] dst,
                                     input logic [13:0] junk);
    return {dst, size, src, junk, op};
  endfunction

  // Reference model in 64-bit arithmetic.
  function automatic logic [31:0] ref_model(input logic [31:0] ins, input logic [31:0] ra,
                                            input logic [31:0] rb);
    longint unsigned m, f, r, win;
    int unsigned src, sz, dst;
    src = ins[21:17]; sz = ins[26:22]; dst = ins[31:27];
    m = (64'd1 << sz) - 1;
    r = 0;
    case (ins[2:0])
      3'd2: begin
        f   = (rb >> src) & m;
        win = m << dst;
        r   = ({32'd0, ra} & ~win) | (f << dst);
      end
      3'd3: begin
        f = (ra >= 32) ? 0 : ((rb >> ra) & m);
        r = f << dst;
      end
      3'd4: begin
        f = (rb >> src) & m;
        r = (ra >= 32) ? 0 : (f << ra);
      end
      default: r = 0;
    endcase
    return r[31:0];
  endfunction

  task automatic drive(input logic [31:0] ins, input logic [31:0] ra,
                       input logic [31:0] rb, input logic [31:0] exp, input string tag);
    @(negedge clk);
    instr = ins; a = ra; b = rb;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  task automatic drive_ref(input logic [31:0] ins, input logic [31:0] ra,
                           input logic [31:0] rb, input string tag);
    drive(ins, ra, rb, ref_model(ins, ra, rb), tag);
  endtask

  // Monitor: compare each result one time step after the edge following its drive.
  initial begin
    forever begin
      @(posedge clk);
      if (exp_q.size() > 0) begin
        logic [31:0] e;
        string t;
        #1ns;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_cmp++;
        if (result !== e) begin
          n_bad++;
          $display("FAIL %s: got %08h expected %08h", t, result, e);
        end
      end
    end
  end

  initial begin
    #(4ns * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    instr = '0; a = '0; b = '0;
    // R2 idle inputs: op 0 gives zero
    drive(32'h0, 32'h0, 32'h0, 32'h0, "R2 idle");
    // R3 insert 8 bits at 8
    drive(mk(3'd2, 5'd0, 5'd8, 5'd8, 14'd0), 32'hFFFF_FFFF, 32'h0000_00A5,
          32'hFFFF_A5FF, "R3 insert");
    drive(mk(3'd2, 5'd4, 5'd4, 5'd28, 14'd0), 32'h0000_0000, 32'h0000_00C0,
          32'hC000_0000, "R3 insert top");
    // R4 source shift from A
    drive(mk(3'd3, 5'd0, 5'd8, 5'd16, 14'd0), 32'd4, 32'h1234_5678,
          32'h0067_0000, "R4 dyn src");
    // R5 destination shift from A
    drive(mk(3'd4, 5'd8, 5'd4, 5'd0, 14'd0), 32'd28, 32'h1234_5678,
          32'h6000_0000, "R5 dyn dst");
    // R6 widths 31 and 1
    drive(mk(3'd3, 5'd0, 5'd31, 5'd0, 14'd0), 32'd0, 32'hFFFF_FFFF,
          32'h7FFF_FFFF, "R6 width31");
    drive(mk(3'd3, 5'd0, 5'd1, 5'd0, 14'd0), 32'd31, 32'h8000_0000,
          32'h0000_0001, "R6 width1");
    drive(mk(3'd2, 5'd0, 5'd31, 5'd1, 14'd0), 32'h0000_0000, 32'hFFFF_FFFF,
          32'hFFFF_FFFE, "R6 insert width31");
    // R7 zero width
    drive(mk(3'd2, 5'd3, 5'd0, 5'd9, 14'd0), 32'hDEAD_BEEF, 32'hFFFF_FFFF,
          32'hDEAD_BEEF, "R7 insert w0");
    drive(mk(3'd3, 5'd3, 5'd0, 5'd9, 14'd0), 32'd1, 32'hFFFF_FFFF,
          32'h0, "R7 dyn src w0");
    drive(mk(3'd4, 5'd3, 5'd0, 5'd9, 14'd0), 32'd1, 32'hFFFF_FFFF,
          32'h0, "R7 dyn dst w0");
    // R8 oversized register shifts
    drive(mk(3'd3, 5'd0, 5'd8, 5'd0, 14'd0), 32'd32, 32'hFFFF_FFFF,
          32'h0, "R8 src 32");
    drive(mk(3'd3, 5'd0, 5'd8, 5'd0, 14'd0), 32'hFFFF_FFFF, 32'hFFFF_FFFF,
          32'h0, "R8 src all ones");
    drive(mk(3'd4, 5'd0, 5'd8, 5'd0, 14'd0), 32'd40, 32'hFFFF_FFFF,
          32'h0, "R8 dst 40");
    drive(mk(3'd4, 5'd0, 5'd8, 5'd0, 14'd0), 32'd33, 32'h0000_0001,
          32'h0, "R8 dst 33");
    // R1 junk in bits [16:3] ignored
    drive(mk(3'd2, 5'd0, 5'd8, 5'd8, 14'h3FFF), 32'hFFFF_FFFF, 32'h0000_00A5,
          32'hFFFF_A5FF, "R1 junk insert");
    drive(mk(3'd4, 5'd8, 5'd4, 5'd0, 14'h2AAA), 32'd28, 32'h1234_5678,
          32'h6000_0000, "R1 junk dyn dst");
    // R2 undefined codes
    for (int k = 0; k < 8; k++) begin
      if (k != 2 && k != 3 && k != 4)
        drive(mk(k[2:0], 5'd0, 5'd31, 5'd0, 14'd0), 32'hFFFF_FFFF, 32'hFFFF_FFFF,
              32'h0, "R2 undefined op");
    end
    // R9 random words against model, same-cycle sampling
    for (int i = 0; i < 600; i++) begin
      logic [31:0] ins, ra, rb;
      ins = $urandom();
      ins[2:0] = 3'd2 + 3'($urandom_range(0, 2));
      ra = (i % 3 == 0) ? 32'($urandom_range(0, 40)) : $urandom();
      rb = $urandom();
      drive_ref(ins, ra, rb, "R9 random");
    end
    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule